// File: doc/BRIEF.md
# Host Interface Mode Decoder with ROM Register Preload

This block reads a 3-bit interface-mode strap while reset is held low. It keeps the last value seen when reset is released. That value is decoded into one-hot enables for the host-bus front ends: a serial port, two parallel bus styles (A and B) and a multiplexed address/data bus. The front ends themselves are outside the block. The block only switches them on or off through these enables.

One strap code turns the block into a boot loader. No host is involved. Right after reset the block reads an external synchronous ROM from address 0 upwards. It writes word n into register n of a 128 x 8 configuration register file, then raises a sticky completion flag. While the load runs, the block reports busy and locks out the host write path. In every other mode the registers keep fixed reset defaults, and the completion flag is raised at once.

Top module: `hostif_mode_loader`

## Requirements
- R1: The latched strap selects exactly one front-end enable: 3'b101 selects en_serial, 3'b100 selects en_par_a, 3'b011 selects en_par_b and 3'b010 selects en_mux.
- R2: Codes 3'b000, 3'b110, 3'b111 and the ROM code 3'b001 leave all four front-end enables low.
- R3: The strap is taken only from its value during reset. After reset is released, strap changes alter neither the enables nor the start of a preload until the next reset.
- R4: With strap 3'b001, the first cycle after reset release shows rom_rd high, rom_addr = 0 and busy high, with no host action.
- R5: The ROM returns data one cycle after the address. The word read at address n ends up in register n.
- R6: The preload presents addresses 0 to 127 once each, in increasing order, on consecutive cycles, and then drops rom_rd.
- R7: In ROM mode, busy stays high until the write of register 127. done rises on the same edge that busy falls, which is 129 clock edges after reset release. done then stays high until reset, and busy and done are never high together.
- R8: Outside ROM mode, done is high and busy low from the first cycle after reset. Register n holds the default (n XOR 8'hA5), truncated to 8 bits.
- R9: A host write (host_wr_en with address and data) is ignored while busy is high and is accepted when busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| mode_strap | input | 3 | Interface-mode strap |
| en_serial | output | 1 | Serial front-end enable |
| en_par_a | output | 1 | Parallel bus style A enable |
| en_par_b | output | 1 | Parallel bus style B enable |
| en_mux | output | 1 | Multiplexed address/data front-end enable |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 7 | ROM word address |
| rom_data | input | 8 | ROM read data, valid one cycle after the address |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 7 | Host write address |
| host_wr_data | input | 8 | Host write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| busy | output | 1 | Preload in progress |
| done | output | 1 | Sticky completion flag |

## Verification
Every cycle, the assertions check the following: the enables are at most one-hot and stay stable after reset, a preload opens at address 0, ROM addresses step by one and stop after 127, done is sticky, and done never overlaps busy. Some behaviour can only be shown by the bench scenarios. These are the full decode table, data landing in the matching register after the ROM latency, the default register contents, the exact 129-edge completion time, and host writes being dropped during the load but taking effect afterwards.

// File: rtl/hostif_pkg.sv
// Shared types for the host interface mode decoder.
// Assumes a 3-bit strap; the code values are fixed by the board convention.
package hostif_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        HIF_OFF_0  = 3'b000,
        HIF_ROM    = 3'b001,
        HIF_MUX    = 3'b010,
        HIF_PAR_B  = 3'b011,
        HIF_PAR_A  = 3'b100,
        HIF_SERIAL = 3'b101,
        HIF_OFF_6  = 3'b110,
        HIF_OFF_7  = 3'b111
    } hif_mode_e;

    typedef struct packed {
        logic serial;
        logic par_a;
        logic par_b;
        logic mux;
    } fe_en_t;

    // Reset default for configuration register idx (callers truncate).
    function automatic logic [31:0] reg_default(input int unsigned idx);
        return idx ^ 32'h0000_00A5;
    endfunction
endpackage

// File: rtl/hif_mode_latch.sv
// Captures the mode strap during reset and decodes it into front-end enables.
// Assumes the strap is stable while reset is low; later changes are ignored.
module hif_mode_latch
    import hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] strap,
    output fe_en_t            fe_en
);
    hif_mode_e mode_q;

    // Track the strap only while reset is asserted, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= hif_mode_e'(strap);
    end

    // Decode the held mode into at most one front-end enable.
    always_comb begin
        fe_en = '0;
        case (mode_q)
            HIF_SERIAL: fe_en.serial = 1'b1;
            HIF_PAR_A:  fe_en.par_a  = 1'b1;
            HIF_PAR_B:  fe_en.par_b  = 1'b1;
            HIF_MUX:    fe_en.mux    = 1'b1;
            default:    fe_en = '0;
        endcase
    end
endmodule

// File: rtl/hif_preload_seq.sv
// Walks a synchronous ROM from address 0 to DEPTH-1 and issues one register
// write per word, one cycle after each address (ROM read latency of 1).
// Assumes start_req is meaningful only while reset is low.
module hif_preload_seq #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic              active_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pend_q;
    logic [ADDR_W-1:0] waddr_q;
    logic              done_q;

    // Address walk, write pipeline stage and sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= start_req;
            addr_q   <= '0;
            pend_q   <= 1'b0;
            waddr_q  <= '0;
            done_q   <= !start_req;
        end else begin
            pend_q  <= active_q;
            waddr_q <= addr_q;
            if (active_q) begin
                if (addr_q == LAST) active_q <= 1'b0;
                else                addr_q   <= addr_q + 1'b1;
            end
            if (pend_q && waddr_q == LAST) done_q <= 1'b1;
        end
    end

    assign rom_rd   = active_q;
    assign rom_addr = addr_q;
    assign wr_en    = pend_q;
    assign wr_addr  = waddr_q;
    assign busy     = active_q | pend_q;
    assign done     = done_q;
endmodule

// File: rtl/hif_cfg_regfile.sv
// Configuration register file: one write port, one combinational read port.
// Each register resets to hostif_pkg::reg_default of its index.
module hif_cfg_regfile
    import hostif_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        localparam logic [DATA_W-1:0] DFLT = DATA_W'(reg_default(i));
        logic [DATA_W-1:0] q;

        // Hold one register: default on reset, load on an address match.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  q <= DFLT;
            else if (wr_en && wr_addr == ADDR_W'(i))     q <= wr_data;
        end
        assign word[i] = q;
    end

    assign rd_data = word[rd_addr];
endmodule

// File: rtl/hostif_mode_loader.sv
// Top: strap decode, ROM preload sequencer and configuration register file.
// Host writes are locked out while the preload runs.
module hostif_mode_loader
    import hostif_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_strap,
    output logic              en_serial,
    output logic              en_par_a,
    output logic              en_par_b,
    output logic              en_mux,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    fe_en_t            fe_en;
    logic              boot_wr;
    logic [ADDR_W-1:0] boot_addr;
    logic              rf_wr;
    logic [ADDR_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_data;

    hif_mode_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (mode_strap),
        .fe_en (fe_en)
    );

    hif_preload_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (mode_strap == HIF_ROM),
        .rom_rd    (rom_rd),
        .rom_addr  (rom_addr),
        .wr_en     (boot_wr),
        .wr_addr   (boot_addr),
        .busy      (busy),
        .done      (done)
    );

    // Pick the register write source: preload first, host only when idle.
    always_comb begin
        if (boot_wr) begin
            rf_wr   = 1'b1;
            rf_addr = boot_addr;
            rf_data = rom_data;
        end else begin
            rf_wr   = host_wr_en && !busy;
            rf_addr = host_wr_addr;
            rf_data = host_wr_data;
        end
    end

    hif_cfg_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr),
        .wr_addr (rf_addr),
        .wr_data (rf_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign en_serial = fe_en.serial;
    assign en_par_a  = fe_en.par_a;
    assign en_par_b  = fe_en.par_b;
    assign en_mux    = fe_en.mux;
endmodule

// File: rtl/hostif_mode_loader_checks.sv
// Cycle-by-cycle properties of hostif_mode_loader, attached with bind.
module hostif_mode_loader_checks #(
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_serial,
    input logic              en_par_a,
    input logic              en_par_b,
    input logic              en_mux,
    input logic              rom_rd,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              busy,
    input logic              done
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
    logic [3:0] en_vec;
    assign en_vec = {en_serial, en_par_a, en_par_b, en_mux};

    a_r1_enables_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_vec));

    a_r3_enables_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(en_vec));

    a_r4_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && rom_rd) |-> (rom_addr == '0 && busy));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && rom_addr != LAST) |=> (rom_rd && rom_addr == $past(rom_addr) + 1'b1));

    a_r6_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && rom_addr == LAST) |=> !rom_rd);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r8_done_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !rom_rd) |-> done);
endmodule

bind hostif_mode_loader hostif_mode_loader_checks #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_serial (en_serial),
    .en_par_a  (en_par_a),
    .en_par_b  (en_par_b),
    .en_mux    (en_mux),
    .rom_rd    (rom_rd),
    .rom_addr  (rom_addr),
    .busy      (busy),
    .done      (done)
);

// File: tb/boot_rom_model.sv
// Synchronous ROM model for the bench: data appears one cycle after the address.
module boot_rom_model (
    input  logic       clk,
    input  logic       rd,
    input  logic [6:0] addr,
    output logic [7:0] data
);
    // Register the addressed word on a read strobe.
    always_ff @(posedge clk) begin
        if (rd) data <= 8'(int'(addr) * 37 + 11);
    end
endmodule

// File: tb/hostif_mode_loader_tb.sv
module hostif_mode_loader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_strap = 3'b000;
    logic       en_serial, en_par_a, en_par_b, en_mux;
    logic       rom_rd;
    logic [6:0] rom_addr;
    logic [7:0] rom_data;
    logic       host_wr_en = 1'b0;
    logic [6:0] host_wr_addr = '0;
    logic [7:0] host_wr_data = '0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, done;

    int checks = 0;
    int failures = 0;
    int mon_idx = 0;
    bit mon_on = 1'b0;

    always #10 clk = ~clk;

    hostif_mode_loader u_dut (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .en_serial(en_serial), .en_par_a(en_par_a), .en_par_b(en_par_b), .en_mux(en_mux),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
    );

    boot_rom_model u_rom (.clk(clk), .rd(rom_rd), .addr(rom_addr), .data(rom_data));

    // Vector: {strap[2:0], expected {serial,par_a,par_b,mux}, rom mode}
    localparam logic [7:0] VEC [8] = '{
        {3'b000, 4'b0000, 1'b0}, {3'b001, 4'b0000, 1'b1},
        {3'b010, 4'b0001, 1'b0}, {3'b011, 4'b0010, 1'b0},
        {3'b100, 4'b0100, 1'b0}, {3'b101, 4'b1000, 1'b0},
        {3'b110, 4'b0000, 1'b0}, {3'b111, 4'b0000, 1'b0}
    };

    function automatic logic [7:0] rom_word(input int n);
        return 8'(n * 37 + 11);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap = strap;
        mon_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [7:0] d);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // R6: address order monitor, sampled between edges.
    always @(negedge clk) begin
        if (mon_on && rst_n && rom_rd) begin
            chk(rom_addr == 7'(mon_idx), "R6 address order", rom_addr, mon_idx);
            mon_idx++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cyc;
        bit busy_ok;

        // Table walk: decode, reset state, start condition.
        for (int k = 0; k < 8; k++) begin
            do_reset(VEC[k][7:5]);
            chk({en_serial, en_par_a, en_par_b, en_mux} == VEC[k][4:1], "R1/R2 decode",
                {en_serial, en_par_a, en_par_b, en_mux}, VEC[k][4:1]);
            chk(done == !VEC[k][0], "R7/R8 done after reset", done, !VEC[k][0]);
            chk(busy == VEC[k][0], "R4/R8 busy after reset", busy, VEC[k][0]);
            if (VEC[k][0]) begin
                chk(rom_rd && rom_addr == 7'd0, "R4 preload starts at 0", rom_addr, 0);
            end else begin
                read_reg(7'd0, v);   chk(v == 8'hA5, "R8 default reg0", v, 8'hA5);
                read_reg(7'd127, v); chk(v == 8'hDA, "R8 default reg127", v, 8'hDA);
                chk(!rom_rd, "R8 no ROM read", rom_rd, 0);
            end
        end

        // Full preload with a blocked host write in the middle.
        do_reset(3'b001);
        mon_on = 1'b1;
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < 400) begin
            if (cyc == 60) begin
                host_write(7'd10, 8'h00);
            end else begin
                @(negedge clk);
            end
            cyc++;
            if (!done && !busy) busy_ok = 1'b0;
            if (done && busy) busy_ok = 1'b0;
        end
        mon_on = 1'b0;
        chk(cyc == 129, "R7 done after 129 edges", cyc, 129);
        chk(busy_ok, "R7 busy until done, no overlap", busy_ok, 1);
        chk(mon_idx == 128, "R6 address count", mon_idx, 128);
        chk(!rom_rd, "R6 rom_rd low after load", rom_rd, 0);
        for (int n = 0; n < 128; n++) begin
            read_reg(7'(n), v);
            if (n == 10) chk(v == rom_word(n), "R9 host write ignored while busy", v, rom_word(n));
            else         chk(v == rom_word(n), "R5 reg holds ROM word", v, rom_word(n));
        end
        repeat (5) @(negedge clk);
        chk(done && !busy, "R7 done sticky", done, 1);
        host_write(7'd10, 8'h3C);
        read_reg(7'd10, v);
        chk(v == 8'h3C, "R9 host write after done", v, 8'h3C);

        // Strap changes after reset are ignored.
        do_reset(3'b101);
        @(negedge clk);
        mode_strap = 3'b001;
        repeat (6) @(negedge clk);
        chk(en_serial && !en_mux, "R3 enables held", {en_serial, en_par_a, en_par_b, en_mux}, 4'b1000);
        chk(!rom_rd && !busy && done, "R3 no late preload", {rom_rd, busy, done}, 3'b001);
        mode_strap = 3'b010;
        repeat (3) @(negedge clk);
        chk({en_serial, en_par_a, en_par_b, en_mux} == 4'b1000, "R3 enables held again",
            {en_serial, en_par_a, en_par_b, en_mux}, 4'b1000);

        // Host write accepted at once outside ROM mode.
        do_reset(3'b011);
        host_write(7'd64, 8'h5E);
        read_reg(7'd64, v);
        chk(v == 8'h5E, "R9 host write when idle", v, 8'h5E);
        read_reg(7'd65, v);
        chk(v == 8'hE4, "R8 neighbour keeps default", v, 8'hE4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule